// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit side of a DMA Ethernet MAC. When it is enabled and receives a start pulse, it walks a ring of two-word descriptors in memory, starting at a base address. For each descriptor it reads the referenced buffer through a simple word-wide memory port and hands the bytes, one per handshake, to the MAC transmit interface. A frame may span several descriptors, and the buffer that carries the last-buffer flag ends the frame. After each frame the engine marks the frame's first descriptor as used, so software can see that the frame has been consumed.

The walk stops at the first descriptor that already has its used flag set. This lets software end a one-frame chain with a dummy descriptor that has both the used and wrap flags set. When the engine stops it raises a sticky completion flag. If it meets a used descriptor partway through a frame, it treats the buffers as exhausted. In that case it records the condition in the first descriptor of the frame and also raises a sticky exhausted flag. Both flags are cleared by writing one to the matching bit of the clear input.

Top module: `tx_desc_engine`

## Requirements
- R1: After a synchronous reset the engine is idle (busy low), no memory request is pending, no byte is offered, and both status flags are low.
- R2: A start pulse is taken only while the transmit enable is high and the engine is idle. The first memory read after an accepted start is at the base address. A start with enable low causes no memory request.
- R3: A descriptor is 8-byte aligned. Word 0 (offset 0) holds the buffer byte address. Word 1 (offset 4) holds the buffer length in bits 10:0, the last-buffer flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31.
- R4: Buffer bytes go out in increasing address order from any byte alignment. Byte lane k of a 32-bit memory word is byte address 4n+k, taken from bits 8k+7:8k. tx_last marks only the final byte of a buffer that has the last-buffer flag. An offered byte and its tx_last stay stable while tx_ready is low.
- R5: The bytes of the consecutive buffers of one frame are concatenated. A zero-length descriptor adds no byte.
- R6: Once the last buffer of a frame has been sent, word 1 of the frame's first descriptor is rewritten with its fetched value plus bit 31. No other descriptor is written.
- R7: After a descriptor that is not used, the next one is fetched at the base address if that descriptor has the wrap flag, and 8 bytes further on otherwise.
- R8: A used descriptor met between frames stops the engine without any write and sets the completion flag (tx_done).
- R9: A used descriptor met inside a frame sends no further byte and never asserts tx_last. It rewrites word 1 of the frame's first descriptor with its fetched value plus bits 31 and 27, then stops, setting both tx_done and tx_exhausted.
- R10: The status flags are sticky. status_clr bit 0 clears tx_done and bit 1 clears tx_exhausted. A set in the same cycle as a clear wins.
- R11: A memory request holds its address, direction and write data until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable; a start is accepted only while high |
| tx_start | input | 1 | One-cycle start pulse |
| base_addr | input | AW | Byte address of the first descriptor, 8-byte aligned |
| status_clr | input | 2 | Write-one-to-clear: bit 0 tx_done, bit 1 tx_exhausted |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | A byte is offered to the MAC |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_ready | input | 1 | MAC takes the byte this cycle |
| busy | output | 1 | Engine is walking the ring |
| tx_done | output | 1 | Sticky: engine stopped on a used descriptor |
| tx_exhausted | output | 1 | Sticky: buffers ran out inside a frame |

## Verification
The assertions check, on every cycle, the properties that do not depend on the data. These are: requests and offered bytes stay stable under back-pressure, every write sets the used bit and targets descriptor word 1, nothing is offered or requested while idle, and the flags rise only as the engine returns to idle. The bench scenarios cover what depends on descriptor contents: byte order from an unaligned buffer, joining buffers across a zero-length descriptor, the fetch address after wrap versus plain advance, the exact word written back in both the normal and the exhausted case, and clearing the two flags independently.

// File: rtl/tx_dfe_pkg.sv
package tx_dfe_pkg;
  localparam int DESC_USED_BIT = 31;
  localparam int DESC_WRAP_BIT = 30;
  localparam int DESC_EXH_BIT  = 27;
  localparam int DESC_LAST_BIT = 15;
  localparam int DESC_LEN_W    = 11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_BUF,
    S_FETCH_CTL,
    S_CHECK,
    S_BUF_RD,
    S_DRAIN,
    S_WBACK,
    S_FINISH
  } dfe_state_t;
endpackage

// File: rtl/tx_dfe_ptr.sv
module tx_dfe_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_base,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(8);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load_base) begin
      ptr <= base_addr;
    end else if (advance) begin
      ptr <= wrap ? base_addr : ptr + STEP;
    end
  end
endmodule

// File: rtl/tx_dfe_ser.sv
module tx_dfe_ser #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] word,
  input  logic [1:0]    lane,
  input  logic [2:0]    cnt,
  input  logic          mark_last,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          idle
);
  logic [WW-1:0] sh;
  logic [2:0]    left;
  logic          lastf;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      left     <= '0;
      lastf    <= 1'b0;
      tx_valid <= 1'b0;
    end else if (load) begin
      sh       <= word >> {lane, 3'b000};
      left     <= cnt;
      lastf    <= mark_last;
      tx_valid <= (cnt != 3'd0);
    end else if (tx_valid && tx_ready) begin
      sh   <= sh >> 8;
      left <= left - 3'd1;
      if (left == 3'd1) tx_valid <= 1'b0;
    end
  end

  assign tx_data = sh[7:0];
  assign tx_last = tx_valid && lastf && (left == 3'd1);
  assign idle    = !tx_valid;

  a_r4_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/tx_dfe_ctrl.sv
module tx_dfe_ctrl
  import tx_dfe_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_enable,
  input  logic          tx_start,
  input  logic [AW-1:0] ptr,
  output logic          ptr_load,
  output logic          ptr_adv,
  output logic          ptr_wrap,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  input  logic          ser_idle,
  output logic          ser_load,
  output logic [1:0]    ser_lane,
  output logic [2:0]    ser_cnt,
  output logic          ser_mark_last,
  output logic          busy,
  output logic          fin_pulse,
  output logic          fin_exh
);
  localparam logic [AW-1:0] W1_OFS = AW'(4);

  dfe_state_t            state;
  logic [AW-1:0]         buf_addr;
  logic [AW-1:0]         first_addr;
  logic [DESC_LEN_W-1:0] remain;
  logic [WW-1:0]         cur_w1;
  logic [WW-1:0]         first_w1;
  logic                  in_frame;
  logic                  hit_exh;
  logic                  go;
  logic                  is_used;
  logic [2:0]            room;
  logic [2:0]            take_n;
  logic [DESC_LEN_W-1:0] cur_len;

  assign go      = tx_start && tx_enable;
  assign is_used = cur_w1[DESC_USED_BIT];
  assign cur_len = cur_w1[DESC_LEN_W-1:0];
  assign room    = 3'd4 - {1'b0, buf_addr[1:0]};
  assign take_n  = (remain < DESC_LEN_W'(room)) ? remain[2:0] : room;

  assign ptr_load = (state == S_IDLE) && go;
  assign ptr_adv  = (state == S_CHECK) && !is_used;
  assign ptr_wrap = cur_w1[DESC_WRAP_BIT];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_FETCH_BUF: begin mem_req = 1'b1; mem_addr = ptr; end
      S_FETCH_CTL: begin mem_req = 1'b1; mem_addr = ptr + W1_OFS; end
      S_BUF_RD:    begin mem_req = 1'b1; mem_addr = {buf_addr[AW-1:2], 2'b00}; end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = first_addr + W1_OFS;
        mem_wdata = first_w1;
        mem_wdata[DESC_USED_BIT] = 1'b1;
        if (hit_exh) mem_wdata[DESC_EXH_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

  assign ser_load      = (state == S_BUF_RD) && mem_ack;
  assign ser_lane      = buf_addr[1:0];
  assign ser_cnt       = take_n;
  assign ser_mark_last = cur_w1[DESC_LAST_BIT] && (remain == DESC_LEN_W'(take_n));
  assign busy          = (state != S_IDLE);
  assign fin_pulse     = (state == S_FINISH);
  assign fin_exh       = hit_exh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      buf_addr   <= '0;
      first_addr <= '0;
      remain     <= '0;
      cur_w1     <= '0;
      first_w1   <= '0;
      in_frame   <= 1'b0;
      hit_exh    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (go) begin
          state    <= S_FETCH_BUF;
          in_frame <= 1'b0;
          hit_exh  <= 1'b0;
        end
        S_FETCH_BUF: if (mem_ack) begin
          buf_addr <= mem_rdata[AW-1:0];
          state    <= S_FETCH_CTL;
        end
        S_FETCH_CTL: if (mem_ack) begin
          cur_w1 <= mem_rdata;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (is_used) begin
            if (in_frame) begin
              hit_exh <= 1'b1;
              state   <= S_WBACK;
            end else begin
              state <= S_FINISH;
            end
          end else begin
            if (!in_frame) begin
              first_addr <= ptr;
              first_w1   <= cur_w1;
              in_frame   <= 1'b1;
            end
            remain <= cur_len;
            if (cur_len == '0)
              state <= cur_w1[DESC_LAST_BIT] ? S_WBACK : S_FETCH_BUF;
            else
              state <= S_BUF_RD;
          end
        end
        S_BUF_RD: if (mem_ack) begin
          buf_addr <= buf_addr + AW'(take_n);
          remain   <= remain - DESC_LEN_W'(take_n);
          state    <= S_DRAIN;
        end
        S_DRAIN: if (ser_idle) begin
          if (remain != '0)                state <= S_BUF_RD;
          else if (cur_w1[DESC_LAST_BIT])  state <= S_WBACK;
          else                             state <= S_FETCH_BUF;
        end
        S_WBACK: if (mem_ack) begin
          in_frame <= 1'b0;
          state    <= hit_exh ? S_FINISH : S_FETCH_BUF;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R11: request fields frozen until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R6: every write marks the descriptor used
  a_r6_write_sets_used: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[DESC_USED_BIT]);
  // R3/R6: writes land on descriptor word 1
  a_r6_write_word1: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_addr[2:0] == 3'b100);
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
  parameter int AW = 16,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_enable,
  input  logic          tx_start,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    status_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          busy,
  output logic          tx_done,
  output logic          tx_exhausted
);
  logic [AW-1:0] ptr;
  logic          ptr_load, ptr_adv, ptr_wrap;
  logic          ser_idle, ser_load, ser_mark_last;
  logic [1:0]    ser_lane;
  logic [2:0]    ser_cnt;
  logic          fin_pulse, fin_exh;

  tx_dfe_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load_base(ptr_load), .advance(ptr_adv),
    .wrap(ptr_wrap), .base_addr(base_addr), .ptr(ptr)
  );

  tx_dfe_ctrl #(.AW(AW), .WW(WW)) u_ctrl (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .tx_start(tx_start),
    .ptr(ptr), .ptr_load(ptr_load), .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_idle(ser_idle), .ser_load(ser_load), .ser_lane(ser_lane),
    .ser_cnt(ser_cnt), .ser_mark_last(ser_mark_last), .busy(busy),
    .fin_pulse(fin_pulse), .fin_exh(fin_exh)
  );

  tx_dfe_ser #(.WW(WW)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .word(mem_rdata),
    .lane(ser_lane), .cnt(ser_cnt), .mark_last(ser_mark_last),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .idle(ser_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done      <= 1'b0;
      tx_exhausted <= 1'b0;
    end else begin
      if (fin_pulse)          tx_done <= 1'b1;
      else if (status_clr[0]) tx_done <= 1'b0;
      if (fin_pulse && fin_exh) tx_exhausted <= 1'b1;
      else if (status_clr[1])   tx_exhausted <= 1'b0;
    end
  end

  a_r2_idle_no_request: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  a_r4_no_byte_when_idle: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);
  a_r8_done_at_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> !busy);
  a_r9_exhaust_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_exhausted) |-> tx_done);
endmodule

// File: tb/sim_tx_desc_engine.sv
`timescale 1ns/1ps
module sim_tx_desc_engine;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_enable = 1'b0;
  logic          tx_start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [1:0]    status_clr = 2'b00;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_last, tx_ready;
  logic [7:0]    tx_data;
  logic          busy, tx_done, tx_exhausted;

  always #2 clk = ~clk;

  tx_desc_engine #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .tx_start(tx_start),
    .base_addr(base_addr), .status_clr(status_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .busy(busy), .tx_done(tx_done),
    .tx_exhausted(tx_exhausted)
  );

  // memory model: 256 words, one-cycle registered acknowledge
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      end
    end
  end

  // back-pressure source
  int  rdy_cnt = 0;
  bit  stall_mode = 1'b0;
  always @(posedge clk) begin
    #1;
    rdy_cnt <= rdy_cnt + 1;
    tx_ready <= stall_mode ? ((rdy_cnt % 3) != 0) : 1'b1;
  end

  // monitors
  logic [7:0]  got_data [0:63];
  logic        got_last [0:63];
  int          n_got = 0;
  logic [15:0] rd_log [0:63];
  int          n_rd = 0;
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready && n_got < 64) begin
      got_data[n_got] = tx_data;
      got_last[n_got] = tx_last;
      n_got = n_got + 1;
    end
    if (!rst && mem_req && mem_ack && !mem_we && n_rd < 64) begin
      rd_log[n_rd] = mem_addr;
      n_rd = n_rd + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [7:0] bf(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic put_desc(input int a, input logic [31:0] bufp, input logic [31:0] w1);
    mem[a >> 2]       = bufp;
    mem[(a >> 2) + 1] = w1;
  endtask

  task automatic run_ring(input int base);
    @(negedge clk);
    status_clr = 2'b11;
    @(negedge clk);
    status_clr = 2'b00;
    n_got = 0;
    n_rd  = 0;
    base_addr = AW'(base);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    while (!tx_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_bytes(input string req, input int addr, input int n, input int pos, input bit last_at_end);
    for (int i = 0; i < n; i++) begin
      chk(req, {24'd0, got_data[pos + i]}, {24'd0, bf(addr + i)});
      chk(req, {31'd0, got_last[pos + i]}, {31'd0, (last_at_end && i == n - 1)});
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 tx_done", {31'd0, tx_done}, 32'd0);
    chk("R1 tx_exhausted", {31'd0, tx_exhausted}, 32'd0);
  endtask

  task automatic t_start_disabled();
    int seen = 0;
    tx_enable = 1'b0;
    base_addr = AW'(16'h40);
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (mem_req || busy) seen++;
      @(negedge clk);
    end
    chk("R2 start ignored while disabled", seen, 0);
    tx_enable = 1'b1;
  endtask

  task automatic t_single_unaligned();
    put_desc(16'h40, 32'h101, 32'h0000_8006);
    put_desc(16'h48, 32'h0,   32'hC000_0000);
    stall_mode = 1'b1;
    run_ring(16'h40);
    stall_mode = 1'b0;
    chk("R2 first read at base", {16'd0, rd_log[0]}, 32'h40);
    chk("R4 byte count", n_got, 6);
    chk_bytes("R4 unaligned bytes", 16'h101, 6, 0, 1'b1);
    chk("R6 first desc used", mem[(16'h44) >> 2], 32'h8000_8006);
    chk("R8 stop desc untouched", mem[(16'h4C) >> 2], 32'hC000_0000);
    chk("R7 last fetch after advance", {16'd0, rd_log[n_rd - 1]}, 32'h4C);
    chk("R8 done", {31'd0, tx_done}, 32'd1);
    chk("R8 not exhausted", {31'd0, tx_exhausted}, 32'd0);
  endtask

  task automatic t_multi_wrap();
    put_desc(16'h80, 32'h200, 32'h0000_0003);
    put_desc(16'h88, 32'h0,   32'h0000_0000);
    put_desc(16'h90, 32'h210, 32'h4000_8002);
    run_ring(16'h80);
    chk("R5 byte count", n_got, 5);
    chk_bytes("R5 first buffer", 16'h200, 3, 0, 1'b0);
    chk_bytes("R5 second buffer", 16'h210, 2, 3, 1'b1);
    chk("R6 first desc used", mem[(16'h84) >> 2], 32'h8000_0003);
    chk("R6 middle desc untouched", mem[(16'h8C) >> 2], 32'h0);
    chk("R6 final desc untouched", mem[(16'h94) >> 2], 32'h4000_8002);
    chk("R7 wrap refetch at base", {16'd0, rd_log[n_rd - 1]}, 32'h84);
  endtask

  task automatic t_exhausted();
    put_desc(16'hC0, 32'h180, 32'h0000_0002);
    put_desc(16'hC8, 32'h0,   32'h8000_0000);
    run_ring(16'hC0);
    chk("R9 byte count", n_got, 2);
    chk_bytes("R9 bytes without last", 16'h180, 2, 0, 1'b0);
    chk("R9 first desc marked", mem[(16'hC4) >> 2], 32'h8800_0002);
    chk("R9 used desc untouched", mem[(16'hCC) >> 2], 32'h8000_0000);
    chk("R9 exhausted flag", {31'd0, tx_exhausted}, 32'd1);
    chk("R9 done flag", {31'd0, tx_done}, 32'd1);
  endtask

  task automatic t_clear();
    @(negedge clk);
    status_clr = 2'b01;
    @(negedge clk);
    status_clr = 2'b00;
    @(negedge clk);
    chk("R10 done cleared", {31'd0, tx_done}, 32'd0);
    chk("R10 exhausted kept", {31'd0, tx_exhausted}, 32'd1);
    status_clr = 2'b10;
    @(negedge clk);
    status_clr = 2'b00;
    @(negedge clk);
    chk("R10 exhausted cleared", {31'd0, tx_exhausted}, 32'd0);
  endtask

  task automatic t_two_frames();
    put_desc(16'h300, 32'h1F0, 32'h0000_8001);
    put_desc(16'h308, 32'h1F8, 32'h0000_8001);
    put_desc(16'h310, 32'h0,   32'h8000_0000);
    run_ring(16'h300);
    chk("R7 byte count", n_got, 2);
    chk_bytes("R7 frame one", 16'h1F0, 1, 0, 1'b1);
    chk_bytes("R7 frame two", 16'h1F8, 1, 1, 1'b1);
    chk("R6 frame one used", mem[(16'h304) >> 2], 32'h8000_8001);
    chk("R6 frame two used", mem[(16'h30C) >> 2], 32'h8000_8001);
    chk("R7 stride of eight", {16'd0, rd_log[n_rd - 1]}, 32'h314);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {bf(4 * i + 3), bf(4 * i + 2), bf(4 * i + 1), bf(4 * i)};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_disabled();
    t_single_unaligned();
    t_multi_wrap();
    t_exhausted();
    t_clear();
    t_two_frames();
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end
endmodule